// File: doc/BRIEF.md
# Page Use and Dirty Status Tracker

This block holds two status bits for every physical page frame and uses them to pick a replacement victim that approximates least-recently-used order. It watches the stream of translated accesses, each giving a frame number and a write flag. Any access marks the frame as used, and a write also marks it as modified. A programmable timer wipes every used mark at a fixed cycle interval. Frames not touched since the last wipe are therefore the preferred victims.

When software asks for an eviction, the block returns a victim frame one cycle later. It also returns a flag that says whether the frame holds modified data, which must be copied out to backing storage before the frame is reused. A separate install input marks a frame as freshly loaded: clean and recently used. The frame count is a parameter, with a default of 32.

The block only reports the victim. It does not change any status bits on an eviction, so the caller installs the new page afterwards.

Top module: `page_status_tracker`

## Requirements
- R1: After a synchronous reset, every used and modified bit is 0, the rotating pointer is 0, and `victim_valid` is 0. The first eviction after reset therefore returns frame 0 with `victim_dirty` 0.
- R2: An access (`acc_valid` = 1) sets the used bit of frame `acc_page`.
- R3: A write access (`acc_valid` = 1 and `acc_write` = 1) sets the modified bit of frame `acc_page`. A read access (`acc_write` = 0) leaves the modified bit unchanged.
- R4: The clear timer behaves as follows:
  - An internal count starts at 0, and is held at 0 while `clear_period` is 0. No clear happens while `clear_period` is 0.
  - For a nonzero period P, all used bits are cleared in the cycle where the count equals P-1, and the count then restarts at 0. Otherwise the count increments.
  - An access or install in the clear cycle keeps that frame's used bit set.
- R5: An install (`inst_valid` = 1) clears the modified bit and sets the used bit of frame `inst_page`. If a write access to the same frame falls in the same cycle, the install wins and the modified bit ends at 0.
- R6: An eviction request picks the lowest-numbered frame whose used bit is 0. The choice is based on the status as it stood before the updates of the request cycle.
- R7: If every used bit is set when an eviction is requested, the victim is the value of the rotating pointer. The pointer advances by one, modulo the frame count, on every eviction request.
- R8: `victim_valid` is high for exactly the one cycle after each eviction request. In that cycle, `victim_page` holds the chosen frame and `victim_dirty` holds that frame's modified bit from the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_period | input | PERIOD_W | Cycles between used-bit wipes; 0 disables the wipe |
| acc_valid | input | 1 | Translated access present this cycle |
| acc_write | input | 1 | Access is a write |
| acc_page | input | IDX_W | Frame number of the access |
| inst_valid | input | 1 | Install a new page into a frame |
| inst_page | input | IDX_W | Frame number being installed |
| evict_req | input | 1 | Request a victim frame |
| victim_valid | output | 1 | Victim result strobe, one cycle after the request |
| victim_page | output | IDX_W | Chosen victim frame |
| victim_dirty | output | 1 | Victim must be written back before reuse |

## Verification
Several functions can land in the same cycle, and the bench provokes each pairing:
- a periodic wipe together with an access to a frame;
- an install together with a write to the same frame;
- an eviction request together with a wipe or an install.

Same-cycle pairs are built by setting the period to 1 for a single cycle, or by driving both requests in one vector. The bench judges each outcome later, through eviction results. A frame that kept its used bit is skipped as a victim. A frame whose modified bit survived reports a write-back when it is later chosen. The victim of an eviction issued in a wipe cycle must reflect the state before the wipe.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;

  // Next state of one frame's used bit: install or access set it, a wipe clears it.
  function automatic logic next_use(input logic cur, input logic acc_hit,
                                    input logic inst_hit, input logic wipe);
    if (inst_hit || acc_hit) return 1'b1;
    if (wipe)                return 1'b0;
    return cur;
  endfunction

  // Next state of one frame's modified bit: install cleans, a write dirties.
  function automatic logic next_dirty(input logic cur, input logic wr_hit,
                                      input logic inst_hit);
    if (inst_hit) return 1'b0;
    if (wr_hit)   return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/ptrk_clear_timer.sv
module ptrk_clear_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period,
  output logic                wipe
);

  logic [PERIOD_W-1:0] cnt_q;

  assign wipe = (period != '0) && (cnt_q >= period - PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (rst || period == '0) begin
      cnt_q <= '0;
    end else if (wipe) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PERIOD_W'(1);
    end
  end

  AST_NO_WIPE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(period) == '0 && period != '0 && period != PERIOD_W'(1) |-> !wipe) // R4
    else $error("wipe right after enabling");

endmodule

// File: rtl/ptrk_status_array.sv
module ptrk_status_array
  import ptrk_pkg::*;
#(
  parameter int NUM_PAGES = 32,
  parameter int IDX_W     = $clog2(NUM_PAGES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [IDX_W-1:0]     acc_page,
  input  logic                 inst_valid,
  input  logic [IDX_W-1:0]     inst_page,
  input  logic                 wipe,
  output logic [NUM_PAGES-1:0] use_bits,
  output logic [NUM_PAGES-1:0] dirty_bits
);

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_frame
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic acc_hit, inst_hit;
    assign acc_hit  = acc_valid  && (acc_page  == MY_IDX);
    assign inst_hit = inst_valid && (inst_page == MY_IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        use_bits[g]   <= 1'b0;
        dirty_bits[g] <= 1'b0;
      end else begin
        use_bits[g]   <= next_use(use_bits[g], acc_hit, inst_hit, wipe);
        dirty_bits[g] <= next_dirty(dirty_bits[g], acc_hit && acc_write, inst_hit);
      end
    end
  end

  AST_ACCESS_MARKS_USED: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> use_bits[$past(acc_page)]) // R2
    else $error("access did not mark frame used");

  AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_write && !(inst_valid && inst_page == acc_page)
    |=> dirty_bits[$past(acc_page)]) // R3
    else $error("write did not mark frame dirty");

  AST_INSTALL_CLEAN: assert property (@(posedge clk) disable iff (rst)
    inst_valid |=> !dirty_bits[$past(inst_page)] && use_bits[$past(inst_page)]) // R5
    else $error("install left frame dirty or unused");

  AST_WIPE_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
    wipe && !acc_valid && !inst_valid |=> use_bits == '0) // R4
    else $error("wipe left a used bit set");

  AST_WIPE_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (rst)
    !inst_valid && !acc_valid |=> $stable(dirty_bits)) // R3
    else $error("modified bits changed without a request");

endmodule

// File: rtl/ptrk_victim_select.sv
module ptrk_victim_select #(
  parameter int NUM_PAGES = 32,
  parameter int IDX_W     = $clog2(NUM_PAGES)
) (
  input  logic [NUM_PAGES-1:0] use_bits,
  input  logic [IDX_W-1:0]     rr_ptr,
  output logic [IDX_W-1:0]     sel_idx,
  output logic                 all_used
);

  logic [IDX_W-1:0] first_free;

  always_comb begin
    first_free = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!use_bits[i]) first_free = IDX_W'(i);
    end
  end

  assign all_used = &use_bits;
  assign sel_idx  = all_used ? rr_ptr : first_free;

  always_comb begin
    if (!all_used) begin
      AST_VICTIM_UNUSED: assert (!use_bits[sel_idx]) // R6
        else $error("victim frame is marked used");
    end
  end

endmodule

// File: rtl/page_status_tracker.sv
module page_status_tracker #(
  parameter int NUM_PAGES = 32,
  parameter int PERIOD_W  = 16,
  localparam int IDX_W    = $clog2(NUM_PAGES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] clear_period,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [IDX_W-1:0]    acc_page,
  input  logic                inst_valid,
  input  logic [IDX_W-1:0]    inst_page,
  input  logic                evict_req,
  output logic                victim_valid,
  output logic [IDX_W-1:0]    victim_page,
  output logic                victim_dirty
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAGES - 1);

  logic                 wipe;
  logic [NUM_PAGES-1:0] use_bits, dirty_bits;
  logic [IDX_W-1:0]     rr_ptr, sel_idx;
  logic                 all_used;

  ptrk_clear_timer #(.PERIOD_W(PERIOD_W)) timer_i (
    .clk(clk), .rst(rst), .period(clear_period), .wipe(wipe)
  );

  ptrk_status_array #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) array_i (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_page(acc_page),
    .inst_valid(inst_valid), .inst_page(inst_page), .wipe(wipe),
    .use_bits(use_bits), .dirty_bits(dirty_bits)
  );

  ptrk_victim_select #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) select_i (
    .use_bits(use_bits), .rr_ptr(rr_ptr), .sel_idx(sel_idx), .all_used(all_used)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr       <= '0;
      victim_valid <= 1'b0;
      victim_page  <= '0;
      victim_dirty <= 1'b0;
    end else begin
      victim_valid <= evict_req;
      if (evict_req) begin
        victim_page  <= sel_idx;
        victim_dirty <= dirty_bits[sel_idx];
        rr_ptr       <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + IDX_W'(1);
      end
    end
  end

  AST_STROBE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    evict_req |=> victim_valid) // R8
    else $error("missing victim strobe");

  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !evict_req |=> !victim_valid) // R8
    else $error("victim strobe without request");

  AST_FULL_USES_POINTER: assert property (@(posedge clk) disable iff (rst)
    evict_req && all_used |=> victim_page == $past(rr_ptr)) // R7
    else $error("full set did not use rotating pointer");

endmodule

// File: tb/page_status_tracker_tb_top.sv
module page_status_tracker_tb_top;

  localparam int NP = 32;
  localparam int PW = 16;
  localparam int VN = 18;

  logic          clk = 1'b0;
  logic          rst;
  logic [PW-1:0] clear_period;
  logic          acc_valid, acc_write, inst_valid, evict_req;
  logic [4:0]    acc_page, inst_page;
  logic          victim_valid, victim_dirty;
  logic [4:0]    victim_page;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic          m_use [NP];
  logic          m_dirty [NP];
  int            m_ptr;
  int            m_cnt;

  always #10 clk = ~clk;

  page_status_tracker #(.NUM_PAGES(NP), .PERIOD_W(PW)) dut_i (
    .clk(clk), .rst(rst), .clear_period(clear_period),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_page(acc_page),
    .inst_valid(inst_valid), .inst_page(inst_page), .evict_req(evict_req),
    .victim_valid(victim_valid), .victim_page(victim_page), .victim_dirty(victim_dirty)
  );

  // Vector layout: {acc_v, acc_w, acc_page[5], inst_v, inst_page[5], evict, period[4]}
  localparam logic [17:0] VEC [VN] = '{
    {1'b1,1'b1,5'd3, 1'b0,5'd0, 1'b0,4'd0}, // R3 write frame 3
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd0}, // R6 victim 0
    {1'b1,1'b0,5'd0, 1'b0,5'd0, 1'b0,4'd0}, // R2 read frame 0
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd0}, // R6 victim 1
    {1'b1,1'b1,5'd1, 1'b0,5'd0, 1'b0,4'd0}, // R3 write frame 1
    {1'b1,1'b1,5'd2, 1'b0,5'd0, 1'b0,4'd0}, // R3 write frame 2
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd0}, // R6 victim 4
    {1'b0,1'b0,5'd0, 1'b1,5'd3, 1'b1,4'd0}, // R5 install 3 with evict
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b0,4'd1}, // R4 single wipe
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd0}, // R6 victim 0
    {1'b1,1'b1,5'd0, 1'b0,5'd0, 1'b0,4'd1}, // R4 wipe with write 0
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd0}, // R8 victim 1 dirty
    {1'b1,1'b1,5'd1, 1'b1,5'd1, 1'b0,4'd0}, // R5 install beats write
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd0}, // R8 victim 2 dirty
    {1'b1,1'b0,5'd2, 1'b0,5'd0, 1'b0,4'd0}, // R3 read keeps dirty
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd0}, // R5 victim 3 clean
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd1}, // R6 evict in wipe cycle
    {1'b0,1'b0,5'd0, 1'b0,5'd0, 1'b1,4'd0}  // R8 victim 0 dirty
  };

  task automatic model_reset();
    for (int i = 0; i < NP; i++) begin
      m_use[i]   = 1'b0;
      m_dirty[i] = 1'b0;
    end
    m_ptr = 0;
    m_cnt = 0;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks its eviction result.
  task automatic step(input logic av, input logic aw, input logic [4:0] ap,
                      input logic iv, input logic [4:0] ip, input logic ev,
                      input logic [PW-1:0] per, input string tag);
    logic wipe;
    int   exp_pg;
    logic exp_d;
    logic full;
    acc_valid = av; acc_write = aw; acc_page = ap;
    inst_valid = iv; inst_page = ip; evict_req = ev; clear_period = per;
    full = 1'b1;
    exp_pg = m_ptr;
    for (int i = NP - 1; i >= 0; i--) begin
      if (!m_use[i]) begin
        full = 1'b0;
        exp_pg = i;
      end
    end
    exp_d = m_dirty[exp_pg];
    wipe = (per != 0) && (m_cnt >= int'(per) - 1);
    @(posedge clk);
    @(negedge clk);
    check({tag, " R8 strobe"}, int'(victim_valid), int'(ev));
    if (ev) begin
      check({tag, full ? " R7 page" : " R6 page"}, int'(victim_page), exp_pg);
      check({tag, " R8 dirty"}, int'(victim_dirty), int'(exp_d));
      m_ptr = (m_ptr + 1) % NP;
    end
    if (per == 0 || wipe) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    for (int i = 0; i < NP; i++) begin
      if ((iv && int'(ip) == i) || (av && int'(ap) == i)) m_use[i] = 1'b1;
      else if (wipe) m_use[i] = 1'b0;
    end
    if (av && aw) m_dirty[ap] = 1'b1;
    if (iv) m_dirty[ip] = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    acc_valid = 0; acc_write = 0; acc_page = 0;
    inst_valid = 0; inst_page = 0; evict_req = 0; clear_period = 0;
    repeat (3) @(negedge clk);
    check("R1 strobe low in reset", int'(victim_valid), 0);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(0,0,0, 0,0, 1, 0, "R1 first evict");
    do_reset();

    for (int v = 0; v < VN; v++) begin
      logic [17:0] w;
      w = VEC[v];
      step(w[17], w[16], w[15:11], w[10], w[9:5], w[4], PW'(w[3:0]), "R6 table");
    end

    // R2 mark all frames used, then R7 rotating pointer picks victims
    for (int p = 0; p < NP; p++) step(1, p[0], 5'(p), 0,0, 0, 0, "R2 fill");
    for (int k = 0; k < 4; k++) step(0,0,0, 0,0, 1, 0, "R7 full");

    // R4 periodic wipe with period 5 while evicting every cycle
    for (int p = 0; p < NP; p++) step(1, 0, 5'(p), 0,0, 0, 0, "R2 refill");
    for (int k = 0; k < 12; k++) begin
      step(k == 7, 0, 5'd0, 0,0, 1, 16'd5, "R4 periodic");
    end
    step(0,0,0, 0,0, 0, 0, "R4 off");

    // R1 reset in mid-run restores pointer and bits
    for (int p = 0; p < NP; p++) step(1, 1, 5'(p), 0,0, 0, 0, "R3 fill dirty");
    step(0,0,0, 0,0, 1, 0, "R7 before reset");
    do_reset();
    step(0,0,0, 0,0, 1, 0, "R1 after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule